// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block moves a fixed run of bytes from any 256-byte-aligned region of a 16-bit address space into the sprite attribute table. The CPU starts a transfer by writing a page number to one trigger address. The upper address byte of the source is that page number and the lower byte counts up from zero. The destination counts up from a fixed base.

While the copy runs, the engine is the bus master. Every byte costs two cycles: in a read cycle the engine drives the source address with a read strobe, and it captures the returned byte at the end of that cycle. In the write cycle that follows, it drives the destination address, the captured byte and a write strobe. A busy output covers the whole transfer, so that the surrounding logic can hold the CPU off the bus. A new trigger write during a transfer abandons it and starts again from the first byte with the new page.

Top module: `sprite_dma`

## Requirements
- R1: After reset, busy, busRd and busWr are 0.
- R2: A CPU write with cpuWrAddr equal to 0xFF46 starts a transfer whatever the data value, and busy is 1 in the next cycle. CPU writes to any other address have no effect: busy and both strobes stay 0.
- R3: For byte index i (0 to 159), the read cycle drives busAddr = {page, i[7:0]} with busRd = 1, where page is the written byte. The first read uses low byte 0x00.
- R4: For byte index i, the write cycle drives busAddr = 0xFE00 + i with busWr = 1.
- R5: A transfer is exactly 160 read/write pairs in strict alternation, starting with a read. busRd and busWr are never 1 in the same cycle.
- R6: busWdata in each write cycle equals the busRdata value presented in the read cycle just before it. busRdata is sampled at the end of a cycle in which busRd is 1.
- R7: busy is 1 from the cycle after the trigger through the last write cycle, and 0 in the cycle after that.
- R8: A trigger write during a transfer, in either a read or a write cycle, makes the next cycle the read of byte 0 with the new page. The old transfer does not continue.
- R9: While busy is 0, busAddr and busWdata are 0 and no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU register write strobe |
| cpuWrAddr | input | 16 | CPU write address |
| cpuWrData | input | 8 | CPU write data (source page) |
| busAddr | output | 16 | Bus master address |
| busRd | output | 1 | Bus master read strobe |
| busWr | output | 1 | Bus master write strobe |
| busRdata | input | 8 | Read data, valid in the read-strobe cycle |
| busWdata | output | 8 | Write data |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check the local rules on every cycle: the strobes never overlap, each read is followed by a write unless a trigger cuts in, each write carries the previous read's data, destinations stay inside the table window, the bus is quiet when idle, and busy falls only after a write. The byte count, the exact source and destination address of every index, and a restart taking effect mid-transfer depend on the whole sequence, so only the bench's scenarios show them. The bench copies from all 256 source pages and restarts a transfer in both phases.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPage;
    logic clearCount;
    logic incCount;
    logic captureByte;
    logic driveRead;
    logic driveWrite;
  } dmaStrobes_t;

endpackage

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic              lastByte,
  output dmaStrobes_t       strobes,
  output logic              busy
);

  dmaState_t state, stateNext;
  logic trigHit;

  assign trigHit = cpuWrEn && (cpuWrAddr == TRIG_ADDR);

  // A trigger takes priority over the running sequence (restart)
  always_comb begin
    stateNext = state;
    if (trigHit) begin
      stateNext = ST_READ;
    end else begin
      case (state)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_READ:  stateNext = ST_WRITE;
        ST_WRITE: stateNext = lastByte ? ST_IDLE : ST_READ;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.loadPage    = trigHit;
    strobes.clearCount  = trigHit;
    strobes.incCount    = !trigHit && (state == ST_WRITE) && !lastByte;
    strobes.captureByte = (state == ST_READ);
    strobes.driveRead   = (state == ST_READ);
    strobes.driveWrite  = (state == ST_WRITE);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strobes,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] busRdata,
  output logic              lastByte,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata
);

  localparam int OFF_W = ADDR_W - DATA_W;
  localparam int CNT_W = $clog2(XFER_LEN);

  logic [DATA_W-1:0] pageReg;
  logic [CNT_W-1:0]  byteIdx;
  logic [DATA_W-1:0] byteReg;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      byteIdx <= '0;
      byteReg <= '0;
    end else begin
      if (strobes.loadPage)    pageReg <= cpuWrData;
      if (strobes.clearCount)  byteIdx <= '0;
      else if (strobes.incCount) byteIdx <= byteIdx + 1'b1;
      if (strobes.captureByte) byteReg <= busRdata;
    end
  end

  assign lastByte = (byteIdx == CNT_W'(XFER_LEN - 1));
  assign srcAddr  = {pageReg, OFF_W'(byteIdx)};
  assign dstAddr  = DEST_BASE + ADDR_W'(byteIdx);

  always_comb begin
    busAddr = '0;
    if (strobes.driveRead)       busAddr = srcAddr;
    else if (strobes.driveWrite) busAddr = dstAddr;
  end

  assign busRd    = strobes.driveRead;
  assign busWr    = strobes.driveWrite;
  assign busWdata = strobes.driveWrite ? byteReg : '0;

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] busWdata,
  output logic              busy
);

  dmaStrobes_t strobes;
  logic lastByte;

  sprite_dma_ctrl #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWrEn  (cpuWrEn),
    .cpuWrAddr(cpuWrAddr),
    .lastByte (lastByte),
    .strobes  (strobes),
    .busy     (busy)
  );

  sprite_dma_path #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .XFER_LEN (XFER_LEN),
    .DEST_BASE(DEST_BASE)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cpuWrData(cpuWrData),
    .busRdata (busRdata),
    .lastByte (lastByte),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata)
  );

endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWrEn,
  input logic [ADDR_W-1:0] cpuWrAddr,
  input logic [DATA_W-1:0] cpuWrData,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] busWdata,
  input logic              busy
);

  localparam int OFF_W = ADDR_W - DATA_W;
  logic trigHit;
  assign trigHit = cpuWrEn && (cpuWrAddr == TRIG_ADDR);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !busy && !busRd && !busWr);

  p_trig_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigHit |=> busy && busRd && busAddr == {$past(cpuWrData), OFF_W'(0)});

  p_dest_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (busAddr >= DEST_BASE) && (busAddr < DEST_BASE + ADDR_W'(XFER_LEN)));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !trigHit |=> busWr);

  p_write_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && $past(busRd) |-> busWdata == $past(busRdata));

  p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(busWr));

  p_busy_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busRd ^ busWr));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busRd && !busWr && busAddr == '0 && busWdata == '0);

endmodule

bind sprite_dma sprite_dma_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .XFER_LEN (XFER_LEN),
  .TRIG_ADDR(TRIG_ADDR),
  .DEST_BASE(DEST_BASE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuWrEn  (cpuWrEn),
  .cpuWrAddr(cpuWrAddr),
  .cpuWrData(cpuWrData),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busRdata (busRdata),
  .busWdata (busWdata),
  .busy     (busy)
);

// File: tb/sprite_dma_tb.sv
`timescale 1ns/1ps
module sprite_dma_tb;

  localparam int XFER = 160;
  localparam logic [15:0] TRIG = 16'hFF46;
  localparam logic [15:0] DEST = 16'hFE00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWrEn = 1'b0;
  logic [15:0] cpuWrAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [15:0] busAddr;
  logic busRd, busWr, busy;
  logic [7:0] busRdata, busWdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Source memory model: contents are a function of the address
  function automatic logic [7:0] srcByte(logic [15:0] a);
    return a[15:8] ^ (a[7:0] * 8'd5 + 8'd3);
  endfunction

  assign busRdata = busRd ? srcByte(busAddr) : 8'h00;

  sprite_dma u_dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
    .cpuWrData(cpuWrData), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busRdata(busRdata), .busWdata(busWdata), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Pack of busy/rd/wr/addr/wdata for compact comparison
  function automatic logic [31:0] busVec(logic b, logic r, logic w, logic [15:0] a, logic [7:0] d);
    return {5'd0, b, r, w, a, d};
  endfunction

  // Drive a CPU write at the current negedge; returns at the next negedge
  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    cpuWrEn = 1'b1; cpuWrAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuWrEn = 1'b0; cpuWrAddr = '0; cpuWrData = '0;
  endtask

  // Check n byte pairs, starting at the negedge of a read cycle
  task automatic stepBytes(input logic [7:0] page, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [15:0] sa;
      sa = {page, 8'(i)};
      chk(busVec(busy, busRd, busWr, busAddr, 8'h00) == busVec(1, 1, 0, sa, 8'h00),
          {tag, " R3 read cycle"}, "bus", busVec(busy, busRd, busWr, busAddr, 8'h00),
          busVec(1, 1, 0, sa, 8'h00));
      @(negedge clk);
      chk(busVec(busy, busRd, busWr, busAddr, busWdata) ==
          busVec(1, 0, 1, DEST + 16'(i), srcByte(sa)),
          {tag, " R4 R6 write cycle"}, "bus", busVec(busy, busRd, busWr, busAddr, busWdata),
          busVec(1, 0, 1, DEST + 16'(i), srcByte(sa)));
      @(negedge clk);
    end
  endtask

  task automatic checkIdle(input string tag);
    chk(busVec(busy, busRd, busWr, busAddr, busWdata) == 32'd0, tag, "idle bus",
        busVec(busy, busRd, busWr, busAddr, busWdata), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset release");

    // R2: non-trigger addresses are ignored
    cpuWrite(16'hFF45, 8'h12);
    checkIdle("R2 ignore FF45");
    cpuWrite(16'hFF47, 8'h34);
    checkIdle("R2 ignore FF47");
    cpuWrite(16'h7F46, 8'h56);
    checkIdle("R2 ignore 7F46");
    @(negedge clk);
    checkIdle("R9 still idle");

    // R2 R3 R4 R5 R6 R7: exhaustive sweep over all source pages
    for (int p = 0; p < 256; p++) begin
      cpuWrite(TRIG, 8'(p));
      stepBytes(8'(p), XFER, "R5 sweep");
      checkIdle("R7 busy drops after last write");
    end

    // R8: restart during a read cycle
    cpuWrite(TRIG, 8'h12);
    stepBytes(8'h12, 3, "R8 pre");
    cpuWrite(TRIG, 8'h34);
    stepBytes(8'h34, XFER, "R8 restart in read");
    checkIdle("R8 idle after restarted transfer");

    // R8: restart during a write cycle
    cpuWrite(TRIG, 8'h56);
    stepBytes(8'h56, 2, "R8 pre");
    @(negedge clk);
    chk(busWr == 1'b1, "R8", "in write cycle", 32'(busWr), 32'd1);
    cpuWrite(TRIG, 8'h78);
    stepBytes(8'h78, XFER, "R8 restart in write");
    checkIdle("R8 idle after write restart");

    // R9: idle holds with data on busRdata side idle
    repeat (2) @(negedge clk);
    checkIdle("R9 idle hold");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule